// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital sequencer that sits in front of a successive-approximation converter. It owns an 8-bit control register, divides the core clock down to an ADC clock, and accepts a conversion request from one of three sources. The sources are a software start pulse, a timer overflow pulse, and an asynchronous external start pin. Each accepted request runs one conversion, which has two phases: an acquisition (track) phase, then a fixed 16-clock conversion phase. A busy flag is high for the whole conversion. The block holds the multiplexer channel code steady for the analog front end.

At the end of a conversion the block captures the converter's result word and raises a one-cycle completion interrupt. It also offers the result on a valid/ready output. The converter never waits for the consumer: there is no back-pressure onto conversions. A result that has not been taken when the next conversion finishes is replaced. Every edge of the external pin gives exactly one conversion. A held level never produces a stream of conversions.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control register is 0, so the block is powered off. Busy, sampling, the interrupt, `res_valid`, `ref_ext` and `mux_code` are all 0.
- R2: Control bit 7 is the power bit. While it is 0, every trigger is ignored. Clearing it during a conversion returns the block to idle. No interrupt is raised and no result is produced.
- R3: `ref_ext` always follows control bit 6. A value of 1 selects the external reference and 0 selects the internal one.
- R4: Control bits 5:4 set the number of core cycles per ADC clock. Code 00 gives 8, 01 gives 4, 10 gives 16 and 11 gives 32.
- R5: Control bits 3:2 hold an acquisition code k. The acquisition phase lasts k+1 ADC clocks, and `sampling` is high during it. Busy is high for exactly (k+1+16) × ratio cycles, starting with the cycle after the acceptance edge.
- R6: `sw_go` is always a trigger while the block is powered. `t2_ovf` is a trigger only when control bit 1 is 1. The external pin is a trigger only when control bit 0 is 1.
- R7: The external pin passes through two synchroniser flops and triggers on its rising edge. Busy rises after the third clock edge that follows the pin's rise. A pin held high gives exactly one conversion.
- R8: A trigger that arrives while a conversion is in progress is ignored. It is neither queued nor restarts the conversion.
- R9: The divider code, the acquisition code and the channel code are captured when a trigger is accepted. Later writes to these fields, and changes to `chan_code`, do not affect that conversion.
- R10: The captured code appears on `mux_code`. `int_sel` marks the internal channels as a one-hot code: 1001 sets bit 0, 1010 sets bit 1, 1011 sets bit 2 and 1100 sets bit 3. Every other code gives 0.
- R11: `done_irq` is high for exactly the first cycle in which busy is low after a completed conversion. In that cycle, `res_data` equals the value of `stub_res` at the final edge, and `res_valid` is 1.
- R12: `res_valid` stays high and `res_data` stays stable until a cycle in which both `res_valid` and `res_ready` are 1. The output then clears at the next edge. A newer result replaces one that has not been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| chan_code | input | 4 | Requested channel code |
| sw_go | input | 1 | Software start pulse |
| t2_ovf | input | 1 | Timer overflow pulse |
| convst_in | input | 1 | Asynchronous external start pin |
| stub_res | input | 12 | Result word from the converter |
| res_ready | input | 1 | Result consumer ready |
| ref_ext | output | 1 | Reference select, 1 = external |
| busy | output | 1 | Conversion in progress |
| sampling | output | 1 | Acquisition phase active |
| mux_code | output | 4 | Channel code held for the multiplexer |
| int_sel | output | 4 | One-hot internal channel select |
| done_irq | output | 1 | One-cycle completion interrupt |
| res_valid | output | 1 | Result available |
| res_data | output | 12 | Latched result word |

## Verification
The assertions check these rules on every cycle:
- Busy drops within a cycle of power-off.
- Busy can fall only with a completion pulse or after power-off.
- The interrupt lasts one cycle and coincides with a valid result.
- `sampling` is high only while busy.
- `mux_code` is held for the whole conversion.
- `int_sel` is never more than one-hot.
- An unaccepted result stays valid and unchanged.

Some behaviour only the bench scenarios can show:
- The exact busy length for every divider and acquisition code.
- The non-monotonic divider order.
- The three-edge latency of the external pin, and that a held pin gives a single conversion.
- That late triggers and late register writes leave a running conversion untouched.
- The decoded value for every channel code.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int DIV_CNT_W = 5;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_CONV = 2'd2
  } phase_t;

  typedef struct packed {
    logic       pwr;
    logic       ref_ext;
    logic [1:0] div_code;
    logic [1:0] acq_code;
    logic       t2_en;
    logic       ext_en;
  } cfg_t;

  // Terminal count of the prescaler (ratio - 1); the ratio order is 8,4,16,32.
  function automatic logic [DIV_CNT_W-1:0] div_limit(input logic [1:0] code);
    logic [DIV_CNT_W:0] ratio;
    if (code == 2'b01) ratio = (DIV_CNT_W+1)'(4);
    else if (code == 2'b00) ratio = (DIV_CNT_W+1)'(8);
    else ratio = (DIV_CNT_W+1)'(8) << (code - 2'd1);
    return DIV_CNT_W'(ratio - 1'b1);
  endfunction

endpackage

// File: rtl/adc_trig_front.sv
module adc_trig_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_go,
  input  logic t2_ovf,
  input  logic convst_in,
  input  logic en_t2,
  input  logic en_ext,
  output logic trig
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   ext_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= convst_in;
  end

  generate
    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[SYNC_STAGES-1];
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~last_q;
  assign trig     = sw_go | (t2_ovf & en_t2) | (ext_rise & en_ext);

endmodule

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q;

  assign tick = !clr && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || tick) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/adc_chan_decode.sv
module adc_chan_decode #(
  parameter int CH_W     = 4,
  parameter int INT_BASE = 9,
  parameter int INT_NUM  = 4
) (
  input  logic [CH_W-1:0]    code,
  output logic [INT_NUM-1:0] sel
);

  generate
    for (genvar i = 0; i < INT_NUM; i++) begin : g_int
      assign sel[i] = (code == CH_W'(INT_BASE + i));
    end
  endgenerate

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int CH_W        = 4,
  parameter int CONV_CLKS   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int INT_BASE    = 9,
  parameter int INT_NUM     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_wdata,
  input  logic [CH_W-1:0]    chan_code,
  input  logic               sw_go,
  input  logic               t2_ovf,
  input  logic               convst_in,
  input  logic [RES_W-1:0]   stub_res,
  input  logic               res_ready,
  output logic               ref_ext,
  output logic               busy,
  output logic               sampling,
  output logic [CH_W-1:0]    mux_code,
  output logic [INT_NUM-1:0] int_sel,
  output logic               done_irq,
  output logic               res_valid,
  output logic [RES_W-1:0]   res_data
);

  localparam int PH_W = $clog2(CONV_CLKS + 1);

  cfg_t            cfg_r;
  phase_t          phase_q;
  logic [PH_W-1:0] ph_cnt_q;
  logic [1:0]      div_q;
  logic [1:0]      acq_q;
  logic            trig;
  logic            tick;
  logic            idle;

  // Control register
  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_r <= '0;
    else if (cfg_we) cfg_r <= cfg_t'(cfg_wdata);
  end

  assign ref_ext  = cfg_r.ref_ext;
  assign idle     = (phase_q == PH_IDLE);
  assign busy     = !idle;
  assign sampling = (phase_q == PH_ACQ);

  adc_trig_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_go     (sw_go),
    .t2_ovf    (t2_ovf),
    .convst_in (convst_in),
    .en_t2     (cfg_r.t2_en),
    .en_ext    (cfg_r.ext_en),
    .trig      (trig)
  );

  // Prescaler restarts on every acceptance so phase lengths are exact
  adc_tick_gen #(.CNT_W(DIV_CNT_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (idle),
    .limit (div_limit(div_q)),
    .tick  (tick)
  );

  adc_chan_decode #(
    .CH_W     (CH_W),
    .INT_BASE (INT_BASE),
    .INT_NUM  (INT_NUM)
  ) u_dec (
    .code (mux_code),
    .sel  (int_sel)
  );

  // Conversion sequencer and result register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      ph_cnt_q  <= '0;
      div_q     <= '0;
      acq_q     <= '0;
      mux_code  <= '0;
      done_irq  <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      done_irq <= 1'b0;
      if (res_valid && res_ready) res_valid <= 1'b0;

      if (!cfg_r.pwr) begin
        phase_q  <= PH_IDLE;
        ph_cnt_q <= '0;
      end else begin
        unique case (phase_q)
          PH_IDLE: begin
            if (trig) begin
              phase_q  <= PH_ACQ;
              ph_cnt_q <= '0;
              div_q    <= cfg_r.div_code;
              acq_q    <= cfg_r.acq_code;
              mux_code <= chan_code;
            end
          end
          PH_ACQ: begin
            if (tick) begin
              if (ph_cnt_q == PH_W'(acq_q)) begin
                phase_q  <= PH_CONV;
                ph_cnt_q <= '0;
              end else begin
                ph_cnt_q <= ph_cnt_q + 1'b1;
              end
            end
          end
          PH_CONV: begin
            if (tick) begin
              if (ph_cnt_q == PH_W'(CONV_CLKS - 1)) begin
                phase_q   <= PH_IDLE;
                ph_cnt_q  <= '0;
                done_irq  <= 1'b1;
                res_valid <= 1'b1;
                res_data  <= stub_res;
              end else begin
                ph_cnt_q <= ph_cnt_q + 1'b1;
              end
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int RES_W   = 12,
  parameter int CH_W    = 4,
  parameter int INT_NUM = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pwr,
  input logic               busy,
  input logic               sampling,
  input logic               done_irq,
  input logic               res_valid,
  input logic               res_ready,
  input logic [RES_W-1:0]   res_data,
  input logic [CH_W-1:0]    mux_code,
  input logic [INT_NUM-1:0] int_sel
);

  // R2
  pwr_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr |=> !busy);

  // R11
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done_irq || !$past(pwr)));

  // R11
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R11
  irq_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (res_valid && !busy));

  // R5
  sample_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sampling |-> busy);

  // R9
  mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(mux_code)));

  // R10
  int_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(int_sel));

  // R12
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid);

  // R12
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (done_irq || $stable(res_data)));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
  .RES_W   (RES_W),
  .CH_W    (CH_W),
  .INT_NUM (INT_NUM)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr       (cfg_r.pwr),
  .busy      (busy),
  .sampling  (sampling),
  .done_irq  (done_irq),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .mux_code  (mux_code),
  .int_sel   (int_sel)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [3:0]  chan_code = '0;
  logic        sw_go = 1'b0;
  logic        t2_ovf = 1'b0;
  logic        convst_in = 1'b0;
  logic [11:0] stub_res = '0;
  logic        res_ready = 1'b1;
  logic        ref_ext, busy, sampling, done_irq, res_valid;
  logic [3:0]  mux_code, int_sel;
  logic [11:0] res_data;

  int checks = 0;
  int errors = 0;
  int cur_len = 0;
  int last_len = 0;
  int done_seen = 0;
  logic prev_busy = 1'b0;

  always #10 clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .chan_code(chan_code), .sw_go(sw_go), .t2_ovf(t2_ovf),
    .convst_in(convst_in), .stub_res(stub_res), .res_ready(res_ready),
    .ref_ext(ref_ext), .busy(busy), .sampling(sampling),
    .mux_code(mux_code), .int_sel(int_sel), .done_irq(done_irq),
    .res_valid(res_valid), .res_data(res_data)
  );

  // Busy-length and interrupt monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (done_irq) done_seen++;
    if (busy) cur_len++;
    else if (prev_busy) begin
      last_len = cur_len;
      cur_len  = 0;
    end
    prev_busy = busy;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse_sw();
    @(negedge clk); sw_go = 1'b1;
    @(negedge clk); sw_go = 1'b0;
  endtask

  task automatic wait_idle(output int len, output int dn);
    while (busy) @(negedge clk);
    #1;
    len = last_len;
    dn  = done_irq;
  endtask

  task automatic run_conv(input string req, input int exp_len, input logic [11:0] res);
    int len, dn;
    stub_res = res;
    pulse_sw();
    check({req, " started"}, busy, 1);
    wait_idle(len, dn);
    check({req, " busy length"}, len, exp_len);
    check({req, " done pulse"}, dn, 1);
    check({req, " result"}, res_data, res);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int len, dn, d0, ratio;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 res_valid", res_valid, 0);
    check("R1 ref_ext", ref_ext, 0);
    check("R1 done_irq", done_irq, 0);
    check("R1 mux_code", mux_code, 0);
    check("R1 sampling", sampling, 0);

    // R2 powered off: triggers ignored
    write_cfg(8'h13);
    d0 = done_seen;
    pulse_sw();
    @(negedge clk); t2_ovf = 1'b1; @(negedge clk); t2_ovf = 1'b0;
    repeat (5) @(negedge clk);
    check("R2 off ignores trigger busy", busy, 0);
    check("R2 off ignores trigger irq", done_seen - d0, 0);

    // R3 reference select
    write_cfg(8'hC0);
    check("R3 ref external", ref_ext, 1);
    write_cfg(8'h80);
    check("R3 ref internal", ref_ext, 0);

    // R4 R5 R11 exhaustive sweep of divider and acquisition codes
    for (int d = 0; d < 4; d++) begin
      for (int a = 0; a < 4; a++) begin
        ratio = (d == 1) ? 4 : (d == 0) ? 8 : (8 << (d - 1));
        write_cfg(8'h80 | 8'(d << 4) | 8'(a << 2));
        run_conv($sformatf("R4 R5 R11 div%0d acq%0d", d, a),
                 (a + 1 + 16) * ratio, 12'(12'h300 + d * 16 + a * 3));
      end
    end

    // R5 sampling during acquisition only
    write_cfg(8'h9C);
    pulse_sw();
    check("R5 sampling at start", sampling, 1);
    repeat (16) @(negedge clk);
    check("R5 sampling after acq", sampling, 0);
    check("R5 still busy", busy, 1);
    wait_idle(len, dn);

    // R9 R10 channel sweep, codes captured at acceptance
    write_cfg(8'h90);
    for (int c = 0; c < 16; c++) begin
      chan_code = 4'(c);
      pulse_sw();
      check("R10 mux_code", mux_code, c);
      check("R10 int_sel", int_sel, (c >= 9 && c <= 12) ? (1 << (c - 9)) : 0);
      chan_code = ~4'(c);
      repeat (3) @(negedge clk);
      check("R9 channel held", mux_code, c);
      wait_idle(len, dn);
    end

    // R9 control writes during a conversion do not alter it
    pulse_sw();
    repeat (5) @(negedge clk);
    write_cfg(8'hBC);
    wait_idle(len, dn);
    check("R9 length after mid write", len, 68);
    write_cfg(8'h90);

    // R6 timer trigger gated by its enable
    @(negedge clk); t2_ovf = 1'b1; @(negedge clk); t2_ovf = 1'b0;
    check("R6 timer disabled", busy, 0);
    write_cfg(8'h92);
    @(negedge clk); t2_ovf = 1'b1; @(negedge clk); t2_ovf = 1'b0;
    check("R6 timer enabled", busy, 1);
    wait_idle(len, dn);
    check("R6 timer length", len, 68);

    // R6 external pin gated by its enable
    write_cfg(8'h90);
    @(negedge clk); convst_in = 1'b1;
    repeat (6) @(negedge clk);
    check("R6 pin disabled", busy, 0);
    convst_in = 1'b0;
    repeat (4) @(negedge clk);

    // R7 synchroniser latency and one conversion per edge
    write_cfg(8'h91);
    @(negedge clk); convst_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R7 not before third edge", busy, 0);
    @(negedge clk);
    check("R7 busy after third edge", busy, 1);
    wait_idle(len, dn);
    check("R7 pin length", len, 68);
    d0 = done_seen;
    repeat (200) @(negedge clk);
    check("R7 held pin no repeat irq", done_seen - d0, 0);
    check("R7 held pin idle", busy, 0);
    convst_in = 1'b0;
    repeat (4) @(negedge clk);
    convst_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 new edge converts", busy, 1);
    wait_idle(len, dn);
    convst_in = 1'b0;

    // R8 triggers while busy are ignored
    write_cfg(8'h93);
    d0 = done_seen;
    pulse_sw();
    repeat (10) @(negedge clk);
    sw_go = 1'b1; t2_ovf = 1'b1; convst_in = 1'b1;
    @(negedge clk);
    sw_go = 1'b0; t2_ovf = 1'b0;
    wait_idle(len, dn);
    check("R8 length unchanged", len, 68);
    repeat (100) @(negedge clk);
    check("R8 no queued start", busy, 0);
    check("R8 single irq", done_seen - d0, 1);
    convst_in = 1'b0;

    // R2 power-off aborts without completion
    write_cfg(8'h90);
    repeat (4) @(negedge clk);
    d0 = done_seen;
    pulse_sw();
    repeat (10) @(negedge clk);
    write_cfg(8'h10);
    repeat (3) @(negedge clk);
    check("R2 abort idle", busy, 0);
    check("R2 abort no irq", done_seen - d0, 0);

    // R12 result hold, replacement and handshake
    write_cfg(8'h90);
    res_ready = 1'b0;
    run_conv("R12 first", 68, 12'hA5C);
    repeat (20) @(negedge clk);
    check("R12 valid held", res_valid, 1);
    check("R12 data held", res_data, 12'hA5C);
    run_conv("R12 replace", 68, 12'h3C1);
    check("R12 valid after replace", res_valid, 1);
    @(negedge clk); res_ready = 1'b1;
    @(negedge clk); res_ready = 1'b0;
    check("R12 cleared by handshake", res_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule